// File: doc/BRIEF.md
# Host and Sequencer Shared Control Register

This block is a single 32-bit control and status word that two agents share: a host on a system bus and a small embedded sequencer that runs a firmware program. Each agent has its own write port and its own read port. Each field of the word gives the two agents different rights. The top bit holds the sequencer in reset. The same bit decides which memory the host may reach: the program store or the working data store. Eight bits carry sequencer status that the host can only read. Eight more bits are a trigger field. The host can only raise these bits, and the sequencer can only lower them.

The block also keeps a run flag. The run flag is 1 after reset. A host request to start a complex operation (a run request carrying a nonzero operation code) sets it again. The sequencer clears it with a pulse. The run flag and the inverse of the lowest status bit are merged into one busy output for the host. The same start request also raises trigger bit 0 automatically, so firmware that polls the trigger field sees the new job. The parameter `PROG_IN_RAM` selects the configuration. With a loadable program store, the sequencer is held in reset after hardware reset. With a fixed program store, the sequencer starts at once.

Top module: `hs_shared_csr`

## Requirements
- R1: In the next cycle after synchronous reset, the readback word is `{PROG_IN_RAM, 0...}`, with status and trigger equal to 0. `busy_o` is 1. `prog_sel_o` equals `PROG_IN_RAM`.
- R2: A host write loads bit 31 (the sequencer hold) from `host_wdata[31]`. Bit 31 of both read ports shows the new value one cycle after the write edge.
- R3: `prog_sel_o` and `data_sel_o` are registered, and exactly one of them is 1. `prog_sel_o` is 1 only while the hold bit is 1 and `PROG_IN_RAM` is 1.
- R4: Bits 15:8 (status) take `seq_wdata[15:8]` on a sequencer write. A host write leaves them unchanged.
- R5: In bits 7:0 (trigger), each 1 in a host write sets the matching bit. A 0 in a host write leaves the bit as it was.
- R6: In bits 7:0, each 0 in a sequencer write clears the matching bit. A 1 in a sequencer write leaves the bit as it was, so the sequencer can never set a bit.
- R7: When a host set and a sequencer clear hit the same trigger bit in one cycle, the bit ends up 1.
- R8: A `host_cplx_req` pulse sets trigger bit 0 and the run flag. If `seq_run_clr` arrives in the same cycle, the set wins.
- R9: `busy_o` equals the run flag OR the inverse of status bit 8, after the current edge has been applied. The run flag resets to 1, and `seq_run_clr` clears it.
- R10: While the hold bit is 1, sequencer writes and `seq_run_clr` have no effect.
- R11: Bits 30:16 always read as 0. Host and sequencer writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host readback of the control word |
| host_cplx_req | input | 1 | Pulse: host start request with a nonzero complex-operation code |
| seq_we | input | 1 | Sequencer write strobe |
| seq_wdata | input | 32 | Sequencer write data |
| seq_rdata | output | 32 | Sequencer readback of the control word |
| seq_run_clr | input | 1 | Pulse: sequencer clears the run flag |
| seq_hold_o | output | 1 | Sequencer held in reset |
| prog_sel_o | output | 1 | Host may access the program store |
| data_sel_o | output | 1 | Host may access the data store |
| busy_o | output | 1 | Merged busy indication for the host |

## Verification
Two pairs of functions can fall on the same edge and need an ordering. The first pair is a host set and a sequencer clear of one trigger bit. The second pair is a complex start request and the sequencer's run-flag clear. The bench first provokes both pairs directly. It then sweeps every combination of the four strobes, with varied data words, while the hold bit is randomly set or released. After each edge it compares every output against a bench-side model. That model encodes the stated precedence: sets beat clears, and the hold bit masks sequencer actions.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int HSC_WORD_W  = 32;
  localparam int HSC_FIELD_W = 8;
endpackage

// File: rtl/hsc_trig.sv
module hsc_trig #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_en,
  input  logic [W-1:0] host_val,
  input  logic         seq_en,
  input  logic [W-1:0] seq_val,
  input  logic         auto_set,
  output logic [W-1:0] trig_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic set_i, clr_i;
    assign set_i = (host_en & host_val[i]) | ((i == 0) ? auto_set : 1'b0);
    assign clr_i = seq_en & ~seq_val[i];

    always_ff @(posedge clk) begin
      if (rst) trig_q[i] <= 1'b0;
      else if (set_i) trig_q[i] <= 1'b1;
      else if (clr_i) trig_q[i] <= 1'b0;
    end

    // R5 / R7: any host set lands, even against a sequencer clear
    p_host_set_r5: assert property (@(posedge clk) disable iff (rst)
      (host_en && host_val[i]) |=> trig_q[i]);
    // R6: a sequencer zero clears when no set competes
    p_seq_clr_r6: assert property (@(posedge clk) disable iff (rst)
      (seq_en && !seq_val[i] && !(host_en && host_val[i]) &&
       !(i == 0 && auto_set)) |=> !trig_q[i]);
  end

  // R6: without a host or auto set no trigger bit may rise
  p_no_seq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (!host_en && !auto_set) |=> ((trig_q & ~$past(trig_q)) == '0));
endmodule

// File: rtl/hsc_status.sv
module hsc_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seq_en,
  input  logic [W-1:0] seq_val,
  output logic [W-1:0] stat_d,
  output logic [W-1:0] stat_q
);
  assign stat_d = seq_en ? seq_val : stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  // R4: status changes only through an effective sequencer write
  p_status_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !seq_en |=> $stable(stat_q));
endmodule

// File: rtl/hsc_hold_sel.sv
module hsc_hold_sel #(
  parameter bit PROG_IN_RAM = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic host_en,
  input  logic host_bit,
  output logic hold_q,
  output logic prog_q,
  output logic data_q
);
  logic hold_d;
  assign hold_d = host_en ? host_bit : hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= PROG_IN_RAM;
      prog_q <= PROG_IN_RAM;
      data_q <= ~PROG_IN_RAM;
    end else begin
      hold_q <= hold_d;
      prog_q <= PROG_IN_RAM & hold_d;
      data_q <= ~(PROG_IN_RAM & hold_d);
    end
  end

  // R3: exactly one memory is reachable by the host
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({prog_q, data_q}) == 1);
  // R3: program access follows the hold bit
  p_prog_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    prog_q == (PROG_IN_RAM && hold_q));
  // R2: a host write lands in the hold bit
  p_hold_load_r2: assert property (@(posedge clk) disable iff (rst)
    host_en |=> hold_q == $past(host_bit));
endmodule

// File: rtl/hsc_busy.sv
module hsc_busy (
  input  logic clk,
  input  logic rst,
  input  logic run_set,
  input  logic run_clr,
  input  logic stat_bit_d,
  input  logic stat_bit_q,
  output logic busy_q
);
  logic run_q, run_d;
  assign run_d = run_set ? 1'b1 : (run_clr ? 1'b0 : run_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b1;
      busy_q <= 1'b1;
    end else begin
      run_q  <= run_d;
      busy_q <= run_d | ~stat_bit_d;
    end
  end

  // R8: a start request always shows as busy on the next cycle
  p_req_busy_r8: assert property (@(posedge clk) disable iff (rst)
    run_set |=> busy_q);
  // R9: a low status bit forces busy
  p_stat_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !stat_bit_q |-> busy_q);
endmodule

// File: rtl/hs_shared_csr.sv
module hs_shared_csr #(
  parameter bit PROG_IN_RAM = 1'b1,
  parameter int WORD_W      = hsc_pkg::HSC_WORD_W,
  parameter int FIELD_W     = hsc_pkg::HSC_FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  input  logic              host_cplx_req,
  input  logic              seq_we,
  input  logic [WORD_W-1:0] seq_wdata,
  output logic [WORD_W-1:0] seq_rdata,
  input  logic              seq_run_clr,
  output logic              seq_hold_o,
  output logic              prog_sel_o,
  output logic              data_sel_o,
  output logic              busy_o
);
  localparam int HOLD_BIT = WORD_W - 1;
  localparam int STAT_LO  = FIELD_W;
  localparam int STAT_HI  = 2 * FIELD_W - 1;
  localparam int PAD_W    = WORD_W - 1 - 2 * FIELD_W;

  logic               hold_q, seq_eff, clr_eff;
  logic [FIELD_W-1:0] trig_q, stat_q, stat_d;
  logic [WORD_W-1:0]  word;
  logic               unused_bits;

  assign seq_eff = seq_we & ~hold_q;
  assign clr_eff = seq_run_clr & ~hold_q;

  hsc_hold_sel #(.PROG_IN_RAM(PROG_IN_RAM)) u_hold (
    .clk(clk), .rst(rst), .host_en(host_we), .host_bit(host_wdata[HOLD_BIT]),
    .hold_q(hold_q), .prog_q(prog_sel_o), .data_q(data_sel_o));

  hsc_trig #(.W(FIELD_W)) u_trig (
    .clk(clk), .rst(rst), .host_en(host_we), .host_val(host_wdata[FIELD_W-1:0]),
    .seq_en(seq_eff), .seq_val(seq_wdata[FIELD_W-1:0]),
    .auto_set(host_cplx_req), .trig_q(trig_q));

  hsc_status #(.W(FIELD_W)) u_stat (
    .clk(clk), .rst(rst), .seq_en(seq_eff), .seq_val(seq_wdata[STAT_HI:STAT_LO]),
    .stat_d(stat_d), .stat_q(stat_q));

  hsc_busy u_busy (
    .clk(clk), .rst(rst), .run_set(host_cplx_req), .run_clr(clr_eff),
    .stat_bit_d(stat_d[0]), .stat_bit_q(stat_q[0]), .busy_q(busy_o));

  assign word       = {hold_q, {PAD_W{1'b0}}, stat_q, trig_q};
  assign host_rdata = word;
  assign seq_rdata  = word;
  assign seq_hold_o = hold_q;

  assign unused_bits = ^{host_wdata[HOLD_BIT-1:STAT_LO], seq_wdata[HOLD_BIT:STAT_HI+1]};

  // R10: a held sequencer cannot move the status field
  p_hold_masks_seq_r10: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> $stable(stat_q));
  // R8: a start request raises trigger bit 0
  p_req_trig_r8: assert property (@(posedge clk) disable iff (rst)
    host_cplx_req |=> trig_q[0]);
  // R11: padding reads as zero
  p_pad_zero_r11: assert property (@(posedge clk) disable iff (rst)
    host_rdata[HOLD_BIT-1:STAT_HI+1] == '0);
endmodule

// File: tb/tb_hs_shared_csr.sv
module tb_hs_shared_csr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0, seq_we = 1'b0, host_cplx_req = 1'b0, seq_run_clr = 1'b0;
  logic [31:0] host_wdata = '0, seq_wdata = '0;
  logic [31:0] host_rdata, seq_rdata;
  logic        seq_hold_o, prog_sel_o, data_sel_o, busy_o;

  int n_chk = 0, n_bad = 0;

  // bench-side model derived from the requirements
  logic       m_hold, m_run;
  logic [7:0] m_stat, m_trig;

  always #4 clk = ~clk;

  hs_shared_csr #(.PROG_IN_RAM(1'b1)) dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_cplx_req(host_cplx_req), .seq_we(seq_we),
    .seq_wdata(seq_wdata), .seq_rdata(seq_rdata), .seq_run_clr(seq_run_clr),
    .seq_hold_o(seq_hold_o), .prog_sel_o(prog_sel_o), .data_sel_o(data_sel_o),
    .busy_o(busy_o));

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [31:0] w;
    w = {m_hold, 15'b0, m_stat, m_trig};
    check(tag, "host_rdata", host_rdata, w);
    check(tag, "seq_rdata", seq_rdata, w);
    check(tag, "busy_o", {31'b0, busy_o}, {31'b0, m_run | ~m_stat[0]});
    check(tag, "prog_sel_o", {31'b0, prog_sel_o}, {31'b0, m_hold});
    check(tag, "data_sel_o", {31'b0, data_sel_o}, {31'b0, ~m_hold});
    check(tag, "seq_hold_o", {31'b0, seq_hold_o}, {31'b0, m_hold});
  endtask

  task automatic step(input string tag, input logic hwe, input logic [31:0] hw,
                      input logic swe, input logic [31:0] sw,
                      input logic cplx, input logic rclr);
    logic seff;
    @(negedge clk);
    host_we = hwe; host_wdata = hw; seq_we = swe; seq_wdata = sw;
    host_cplx_req = cplx; seq_run_clr = rclr;
    seff = swe & ~m_hold;
    m_trig = (m_trig & (seff ? sw[7:0] : 8'hFF)) | (hwe ? hw[7:0] : 8'h00) | {7'b0, cplx};
    if (seff) m_stat = sw[15:8];
    m_run = cplx ? 1'b1 : ((rclr & ~m_hold) ? 1'b0 : m_run);
    if (hwe) m_hold = hw[31];
    @(posedge clk);
    #2;
    host_we = 1'b0; seq_we = 1'b0; host_cplx_req = 1'b0; seq_run_clr = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_hold = 1'b1; m_run = 1'b1; m_stat = 8'h00; m_trig = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1: reset state
    check("R1", "reset word", host_rdata, 32'h8000_0000);
    check("R1", "reset busy", {31'b0, busy_o}, 32'd1);
    check("R3", "reset prog_sel", {31'b0, prog_sel_o}, 32'd1);
    check("R3", "reset data_sel", {31'b0, data_sel_o}, 32'd0);

    // R10: held sequencer writes and run clear ignored; R5 host sets
    step("R10", 1'b0, 32'h0, 1'b1, 32'h0000_0100, 1'b0, 1'b1);
    check("R10", "status while held", host_rdata, 32'h8000_0000);
    step("R5", 1'b1, 32'h8000_00A5, 1'b0, 32'h0, 1'b0, 1'b0);
    step("R10", 1'b0, 32'h0, 1'b1, 32'h0000_0000, 1'b0, 1'b0);
    check("R10", "trigger kept while held", host_rdata, 32'h8000_00A5);
    // R2 release, R5 zero writes ignored, R3 data select
    step("R2", 1'b1, 32'h0000_0000, 1'b0, 32'h0, 1'b0, 1'b0);
    check("R2", "released word", host_rdata, 32'h0000_00A5);
    check("R3", "data_sel after release", {31'b0, data_sel_o}, 32'd1);
    // R4 / R6: sequencer status write and trigger clears
    step("R6", 1'b0, 32'h0, 1'b1, 32'h0000_FF0F, 1'b0, 1'b0);
    check("R6", "trigger after clear", host_rdata, 32'h0000_FF05);
    // R9: run clear
    step("R9", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    check("R9", "busy after run clear", {31'b0, busy_o}, 32'd0);
    // R4 / R11: host write does not touch status or padding
    step("R11", 1'b1, 32'h7FFF_0000, 1'b0, 32'h0, 1'b0, 1'b0);
    check("R4", "host cannot write status", host_rdata, 32'h0000_FF05);
    step("R11", 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    check("R11", "sequencer cannot write padding", host_rdata, 32'h0000_FF05);
    // R7: host set against sequencer clear
    step("R7", 1'b1, 32'h0000_0002, 1'b1, 32'h0000_0100, 1'b0, 1'b0);
    check("R7", "host set wins", host_rdata, 32'h0000_0102);
    // R8: start request sets trigger bit 0 and busy
    step("R8", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0);
    check("R8", "auto trigger", host_rdata, 32'h0000_0103);
    check("R8", "busy after request", {31'b0, busy_o}, 32'd1);
    step("R9", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    check("R9", "busy cleared", {31'b0, busy_o}, 32'd0);
    step("R8", 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b1);
    check("R8", "request beats clear", {31'b0, busy_o}, 32'd1);
    step("R9", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1);
    step("R9", 1'b0, 32'h0, 1'b1, 32'h0000_0003, 1'b0, 1'b0);
    check("R9", "low status bit forces busy", {31'b0, busy_o}, 32'd1);

    // near-exhaustive sweep: all strobe combinations, varied data
    for (int rep = 0; rep < 48; rep++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] hd, sd;
        hd = $urandom;
        sd = $urandom;
        if ((rep % 3) != 0) hd[31] = 1'b0;
        step("R2 R4 R5 R6 R7 R8 R9 R10 R11 sweep", c[0], hd, c[1], sd, c[2], c[3]);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule